// File: doc/BRIEF.md
# PHY Calibrated Power-Up Sequencer

This block is a hardware state machine that brings up the analog side of a PHY in a fixed order. A power-on command first pulls the power-enable and the DLL-enable low so the PHY's calibration logic resets. After a settle time it raises power-enable, waits for the pad calibration and checks the calibration-done flag. If that flag is present it raises DLL-enable, waits for the DLL to lock and checks the DLL-ready flag. A power-off command only pulls both enables low.

Each wait is a cycle count derived from a clock-frequency parameter, rounded up. The two status flags come from another clock domain, so each passes through a two-flop synchronizer before it is sampled. Every command ends with a one-cycle completion pulse and a 2-bit result code. The code reports success, a missing calibration flag or a missing DLL flag. Commands that arrive while a sequence is running are dropped.

Top module: `phy_pwrup_seq`

## Requirements
- R1: After reset, pwr_en_o, dll_en_o, busy_o and done_o are 0 and err_o is 0.
- R2: A command that is accepted drives pwr_en_o and dll_en_o to 0 and busy_o to 1 at the clock edge that samples it.
- R3: A power-off command completes one cycle after acceptance: done_o pulses with err_o = 0 (ok), busy_o is high for exactly one cycle, and both enables stay low.
- R4: For power-on, pwr_en_o rises SETTLE_CYC edges after the accepting edge. SETTLE_CYC = ceil(CLK_HZ x 3000 ns), which is 600 at 200 MHz.
- R5: The synchronized calibration flag is sampled CAL_CYC edges after pwr_en_o rises. CAL_CYC = ceil(CLK_HZ x 5000 ns), which is 1000 at 200 MHz. If the flag is 1, dll_en_o rises at that same edge.
- R6: If the calibration flag is 0 when sampled, done_o pulses one cycle later with err_o = 1. dll_en_o is never raised, and pwr_en_o stays 1 until the next command.
- R7: The synchronized DLL flag is sampled DLL_CYC edges after dll_en_o rises. DLL_CYC = ceil(CLK_HZ x 11000 ns), which is 2200 at 200 MHz. done_o pulses one cycle later, with err_o = 0 if the flag is 1 and err_o = 2 if it is 0. Both enables keep their values.
- R8: done_o is high for exactly one cycle, and busy_o is already 0 in that cycle. err_o changes only together with done_o and holds until the next completion. err_o never takes the value 3.
- R9: cmd_on_i and cmd_off_i are ignored while busy_o is 1. The running sequence keeps its timing and its result.
- R10: If cmd_on_i and cmd_off_i are both high in the same idle cycle, the power-on sequence runs.
- R11: Each status input counts as present only if it went high at least 3 edges before the edge that samples it. A flag that rises at the edge 2 edges before the sampling edge is reported as missing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_on_i | input | 1 | Start power-on sequence (sampled when idle) |
| cmd_off_i | input | 1 | Start power-off (sampled when idle) |
| cal_done_i | input | 1 | Calibration-done flag from the analog side, asynchronous |
| dll_ready_i | input | 1 | DLL-ready flag from the analog side, asynchronous |
| pwr_en_o | output | 1 | Power-enable to the PHY |
| dll_en_o | output | 1 | DLL-enable to the PHY |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Result: 0 ok, 1 calibration timeout, 2 DLL timeout |

## Verification
All outputs are registered, so each result is due a fixed number of edges after the accepting edge, which counts as edge 1:
- both enables are low and busy is high after edge 1;
- power-enable rises after edge SETTLE_CYC+1;
- DLL-enable rises after edge SETTLE_CYC+CAL_CYC+1;
- on success or a DLL timeout, done arrives after edge SETTLE_CYC+CAL_CYC+DLL_CYC+2;
- on a calibration timeout, done arrives after edge SETTLE_CYC+CAL_CYC+2;
- on power-off, done arrives after edge 2.

The bench counts edges from the accepting edge and samples at the falling edge, so each of these indices is compared exactly. The analog model raises each flag a set number of edges after its enable goes high. That delay is placed at the last passing value and the first failing value, which tests the two-flop latency of R11 to the cycle.

// File: rtl/phy_pwrup_pkg.sv
package phy_pwrup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_CAL_WAIT,
    ST_DLL_WAIT,
    ST_FINISH
  } seq_state_t;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_CAL_TMO = 2'd1,
    RES_DLL_TMO = 2'd2
  } seq_result_t;

  // Cycles covering a time in ns at a given clock, rounded up, never below 1.
  function automatic int ns_to_cycles(input longint clk_hz, input longint ns);
    longint c;
    c = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/phy_pwrup_sync.sv
module phy_pwrup_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/phy_pwrup_timer.sv
module phy_pwrup_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/phy_pwrup_fsm.sv
module phy_pwrup_fsm
  import phy_pwrup_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int SETTLE_CYC = 600,
  parameter int CAL_CYC    = 1000,
  parameter int DLL_CYC    = 2200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_on_i,
  input  logic             cmd_off_i,
  input  logic             cal_ok_i,
  input  logic             dll_ok_i,
  input  logic             expired_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             pwr_en_o,
  output logic             dll_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       err_o
);

  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] CAL_LD    = CNT_W'(CAL_CYC - 1);
  localparam logic [CNT_W-1:0] DLL_LD    = CNT_W'(DLL_CYC - 1);

  seq_state_t  state_q, state_d;
  seq_result_t res_q, res_d;
  logic        pwr_d, dll_d, busy_d, done_d;
  logic [1:0]  err_d;

  always_comb begin
    state_d    = state_q;
    res_d      = res_q;
    pwr_d      = pwr_en_o;
    dll_d      = dll_en_o;
    busy_d     = busy_o;
    done_d     = 1'b0;
    err_d      = err_o;
    load_o     = 1'b0;
    load_val_o = SETTLE_LD;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_on_i || cmd_off_i) begin
          pwr_d  = 1'b0;
          dll_d  = 1'b0;
          busy_d = 1'b1;
          res_d  = RES_OK;
          if (cmd_on_i) begin
            state_d    = ST_SETTLE;
            load_o     = 1'b1;
            load_val_o = SETTLE_LD;
          end else begin
            state_d = ST_FINISH;
          end
        end
      end
      ST_SETTLE: begin
        if (expired_i) begin
          pwr_d      = 1'b1;
          state_d    = ST_CAL_WAIT;
          load_o     = 1'b1;
          load_val_o = CAL_LD;
        end
      end
      ST_CAL_WAIT: begin
        if (expired_i) begin
          if (cal_ok_i) begin
            dll_d      = 1'b1;
            state_d    = ST_DLL_WAIT;
            load_o     = 1'b1;
            load_val_o = DLL_LD;
          end else begin
            res_d   = RES_CAL_TMO;
            state_d = ST_FINISH;
          end
        end
      end
      ST_DLL_WAIT: begin
        if (expired_i) begin
          res_d   = dll_ok_i ? RES_OK : RES_DLL_TMO;
          state_d = ST_FINISH;
        end
      end
      ST_FINISH: begin
        busy_d  = 1'b0;
        done_d  = 1'b1;
        err_d   = res_q;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      res_q    <= RES_OK;
      pwr_en_o <= 1'b0;
      dll_en_o <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 2'd0;
    end else begin
      state_q  <= state_d;
      res_q    <= res_d;
      pwr_en_o <= pwr_d;
      dll_en_o <= dll_d;
      busy_o   <= busy_d;
      done_o   <= done_d;
      err_o    <= err_d;
    end
  end

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
  import phy_pwrup_pkg::*;
#(
  parameter longint CLK_HZ    = 200_000_000,
  parameter longint SETTLE_NS = 3000,
  parameter longint CAL_NS    = 5000,
  parameter longint DLL_NS    = 11000,
  parameter int     SYNC_STG  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_on_i,
  input  logic       cmd_off_i,
  input  logic       cal_done_i,
  input  logic       dll_ready_i,
  output logic       pwr_en_o,
  output logic       dll_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] err_o
);

  localparam int SETTLE_CYC = ns_to_cycles(CLK_HZ, SETTLE_NS);
  localparam int CAL_CYC    = ns_to_cycles(CLK_HZ, CAL_NS);
  localparam int DLL_CYC    = ns_to_cycles(CLK_HZ, DLL_NS);
  localparam int MAX_CYC    = (SETTLE_CYC > CAL_CYC) ?
                              ((SETTLE_CYC > DLL_CYC) ? SETTLE_CYC : DLL_CYC) :
                              ((CAL_CYC > DLL_CYC) ? CAL_CYC : DLL_CYC);
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  logic [1:0]       flags_s;
  logic             cal_ok_s, dll_ok_s;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  phy_pwrup_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({dll_ready_i, cal_done_i}),
    .sync_o  (flags_s)
  );
  assign cal_ok_s = flags_s[0];
  assign dll_ok_s = flags_s[1];

  phy_pwrup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  phy_pwrup_fsm #(
    .CNT_W      (CNT_W),
    .SETTLE_CYC (SETTLE_CYC),
    .CAL_CYC    (CAL_CYC),
    .DLL_CYC    (DLL_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cmd_on_i   (cmd_on_i),
    .cmd_off_i  (cmd_off_i),
    .cal_ok_i   (cal_ok_s),
    .dll_ok_i   (dll_ok_s),
    .expired_i  (tmr_expired),
    .load_o     (tmr_load),
    .load_val_o (tmr_val),
    .pwr_en_o   (pwr_en_o),
    .dll_en_o   (dll_en_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

endmodule

// File: rtl/phy_pwrup_seq_chk.sv
module phy_pwrup_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_en,
  input logic       dll_en,
  input logic       busy,
  input logic       done,
  input logic [1:0] err,
  input logic       cal_ok_s
);

  assert_accept_drops_enables_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!pwr_en && !dll_en));

  assert_dll_after_cal_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(dll_en) |-> ($past(cal_ok_s) && pwr_en));

  assert_dll_needs_power_R6: assert property (@(posedge clk) disable iff (rst)
    dll_en |-> pwr_en);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_err_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(err));

  assert_err_legal_R8: assert property (@(posedge clk) disable iff (rst)
    err != 2'd3);

  assert_fall_only_on_accept_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(pwr_en) || $fell(dll_en)) |-> $rose(busy));

  assert_power_rise_in_seq_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> (busy && !dll_en));

endmodule

bind phy_pwrup_seq phy_pwrup_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwr_en   (pwr_en_o),
  .dll_en   (dll_en_o),
  .busy     (busy_o),
  .done     (done_o),
  .err      (err_o),
  .cal_ok_s (cal_ok_s)
);

// File: tb/phy_pwrup_seq_tb.sv
module phy_pwrup_seq_tb_top;

  localparam longint CLK_HZ = 200_000_000;
  localparam int S = int'((CLK_HZ * 3000 + 999_999_999) / 1_000_000_000);
  localparam int C = int'((CLK_HZ * 5000 + 999_999_999) / 1_000_000_000);
  localparam int D = int'((CLK_HZ * 11000 + 999_999_999) / 1_000_000_000);
  localparam int NEVER = 1_000_000;
  localparam int LIMIT = 10_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_on = 1'b0, cmd_off = 1'b0;
  logic cal_raw, dll_raw;
  logic pwr_en, dll_en, busy, done;
  logic [1:0] err;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int cal_dly = 50, dll_dly = 50;
  int pcnt = 0, dcnt = 0;
  int k_pwr, k_dll, k_done, inject_k;
  logic low_at1, busy_at1, busy_at_done, done_after;

  always #2.5 clk = ~clk;

  phy_pwrup_seq #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst(rst), .cmd_on_i(cmd_on), .cmd_off_i(cmd_off),
    .cal_done_i(cal_raw), .dll_ready_i(dll_raw),
    .pwr_en_o(pwr_en), .dll_en_o(dll_en), .busy_o(busy),
    .done_o(done), .err_o(err)
  );

  // Analog model: each flag rises a set number of edges after its enable goes high.
  always @(posedge clk) begin
    pcnt <= pwr_en ? ((pcnt < NEVER) ? pcnt + 1 : pcnt) : 0;
    dcnt <= dll_en ? ((dcnt < NEVER) ? dcnt + 1 : dcnt) : 0;
  end
  assign cal_raw = pwr_en && (pcnt >= cal_dly);
  assign dll_raw = dll_en && (dcnt >= dll_dly);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic on, input logic off);
    int k;
    k_pwr = 0; k_dll = 0; k_done = 0; k = 0;
    @(negedge clk);
    cmd_on = on; cmd_off = off;
    while (k_done == 0 && k < LIMIT) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      cmd_on = 1'b0; cmd_off = 1'b0;
      if (k == inject_k) begin cmd_on = 1'b1; cmd_off = 1'b1; end
      if (k == 1) begin
        low_at1  = !pwr_en && !dll_en;
        busy_at1 = busy;
      end
      if (pwr_en && k_pwr == 0) k_pwr = k;
      if (dll_en && k_dll == 0) k_dll = k;
      if (done) begin k_done = k; busy_at_done = busy; end
    end
    cmd_on = 1'b0; cmd_off = 1'b0;
    @(posedge clk);
    @(negedge clk);
    done_after = done;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150_000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    inject_k = -1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pwr_en", pwr_en, 0);
    check("R1 dll_en", dll_en, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 err", err, 0);

    // nominal power-on
    run_cmd(1'b1, 1'b0);
    check("R2 enables low", low_at1, 1);
    check("R2 busy", busy_at1, 1);
    check("R4 pwr rise", k_pwr, S + 1);
    check("R5 dll rise", k_dll, S + C + 1);
    check("R7 done time", k_done, S + C + D + 2);
    check("R7 err ok", err, 0);
    check("R8 busy at done", busy_at_done, 0);
    check("R8 done width", done_after, 0);
    check("R7 pwr kept", pwr_en, 1);
    check("R7 dll kept", dll_en, 1);

    // power-off
    run_cmd(1'b0, 1'b1);
    check("R2 off enables low", low_at1, 1);
    check("R3 done time", k_done, 2);
    check("R3 err", err, 0);
    check("R3 pwr low", pwr_en, 0);
    check("R3 dll low", dll_en, 0);
    check("R3 busy after", busy, 0);

    // calibration boundary: latest passing delay
    cal_dly = C - 3;
    run_cmd(1'b1, 1'b0);
    check("R11 cal pass dll", k_dll, S + C + 1);
    check("R11 cal pass err", err, 0);

    // calibration boundary: first failing delay
    cal_dly = C - 2;
    run_cmd(1'b1, 1'b0);
    check("R6 cal fail done", k_done, S + C + 2);
    check("R6 cal fail err", err, 1);
    check("R6 dll never", k_dll, 0);
    check("R6 pwr kept", pwr_en, 1);
    repeat (5) @(negedge clk);
    check("R8 err holds", err, 1);
    check("R6 dll still low", dll_en, 0);
    cal_dly = 50;

    // DLL boundary: latest passing delay
    dll_dly = D - 3;
    run_cmd(1'b1, 1'b0);
    check("R11 dll pass err", err, 0);

    // DLL boundary: first failing delay
    dll_dly = D - 2;
    run_cmd(1'b1, 1'b0);
    check("R7 dll fail done", k_done, S + C + D + 2);
    check("R7 dll fail err", err, 2);
    check("R7 pwr kept fail", pwr_en, 1);
    check("R7 dll kept fail", dll_en, 1);
    dll_dly = 50;

    // commands during busy are ignored
    run_cmd(1'b0, 1'b1);
    inject_k = S + 10;
    run_cmd(1'b1, 1'b0);
    check("R9 dll time", k_dll, S + C + 1);
    check("R9 done time", k_done, S + C + D + 2);
    check("R9 err", err, 0);
    inject_k = 3;
    run_cmd(1'b1, 1'b0);
    check("R9 early pwr time", k_pwr, S + 1);
    check("R9 early done time", k_done, S + C + D + 2);
    inject_k = -1;

    // both commands together: power-on wins
    run_cmd(1'b1, 1'b1);
    check("R10 pwr rise", k_pwr, S + 1);
    check("R10 done time", k_done, S + C + D + 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule